// File: doc/BRIEF.md
# Prescaled Modulo-255 PWM Generator

This block produces a pulse-width modulated waveform from an 8-bit period counter. The counter runs through 255 states (0 to 254) and then returns to 0. A prescaler holds back its advance: the prescaler is fed at half the clock rate and lets the counter step once every (1 + prescale) of those half-rate ticks. The output is high from the moment the counter equals the active compare value until the counter next returns to zero. Because the counter never reaches 255, a compare of 0 keeps the output high and a compare of 255 keeps it low. One PWM period is therefore 2 × (1 + prescale) × 255 clocks.

Software reaches three registers over a simple single-cycle bus. The first is the compare value. It is double-buffered and moves into use only at a counter wrap. The second is the prescale value. The third is a control register that switches the pin between the PWM waveform and the ordinary port output value, and that enables a one-cycle interrupt pulse on each wrap. The counter runs whether or not the pin carries the PWM, so the block also serves as an interval timer. While the chip is idle or powered down, the counter and prescaler hold their state. A pin that is in PWM mode is driven high during those states.

Top module: `pwm255_gen`

## Requirements
- R1: The counter steps once every 2 × (1 + prescale) clocks and returns from 254 to 0. A wrap therefore occurs exactly every 510 × (1 + prescale) clocks.
- R2: For a compare value C with 1 ≤ C ≤ 254 and the PWM on the pin, the pin is high while the counter is in C..254 and low while it is in 0..C−1. Each period then holds (255 − C) × 2 × (1 + prescale) high clocks.
- R3: A compare value of 0 makes the pin high in every clock of the period. Setting the output at a match takes priority over clearing it at zero.
- R4: A compare value of 255 makes the pin low in every clock of the period.
- R5: A compare value written in the middle of a period leaves that period unchanged. The new value takes effect from the next wrap.
- R6: When control bit 0 (output enable) is 0, the pin equals the port output input `io_out_i`. The counter keeps running, and wrap pulses keep their period.
- R7: After reset, all three registers read 0 and the pin follows `io_out_i`.
- R8: While `idle_i` or `pdown_i` is high, the counter and prescaler hold their state. Each clock spent frozen delays the next wrap by one clock. An enabled pin is driven high during that time.
- R9: `wrap_irq_o` pulses high for one clock, one clock after each wrap, but only when control bit 1 (wrap interrupt enable) is 1. When that bit is 0, no pulse appears.
- R10: The register addresses are 0 for compare, 1 for prescale and 2 for control, using bits 1:0. `rd_data_o` returns the last written value of the register selected by `addr_i`, with the unused control bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idle_i | input | 1 | Chip idle state; freezes the counter |
| pdown_i | input | 1 | Chip power-down state; freezes the counter |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for reads and writes |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for the selected register |
| io_out_i | input | 1 | Ordinary port output value, used when the PWM is off |
| pwm_pin_o | output | 1 | Pin output |
| wrap_irq_o | output | 1 | One-clock pulse on each counter wrap |

## Verification
The bench sweeps compare values from the ends of the range (0, 1, 2, 253, 254, 255) and from the middle against three prescale settings. For each pair it counts the high clocks over exactly one wrap-to-wrap window. An off-by-one in the modulus or the prescaler would show up as a wrong window length. A design that clears at zero before it sets at a match would produce a dip for compare 0. The bench also rewrites the compare value in the middle of a period, which catches a missing shadow register because the high count of that period would change. It inserts freeze windows of known length and expects the wrap to slip by exactly that many clocks. It also checks that disabling the pin neither stops the counter nor leaks the waveform.

// File: rtl/pwm255_pkg.sv
package pwm255_pkg;

   // register select, decoded from the bus address
   typedef enum logic [1:0] {
      SEL_CMP  = 2'd0,
      SEL_PRE  = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   // control register: bit 1 wrap interrupt enable, bit 0 pin output enable
   typedef struct packed {
      logic irq_en;
      logic out_en;
   } ctrl_t;

endpackage

// File: rtl/pwm255_regs.sv
module pwm255_regs
   import pwm255_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8,
   parameter int PRE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [1:0]        addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [CNT_W-1:0]  cmp_o,
   output logic [PRE_W-1:0]  pre_o,
   output ctrl_t             ctrl_o
);

   localparam int CTRL_W = $bits(ctrl_t);

   reg_sel_e sel;
   assign sel = reg_sel_e'(addr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_o  <= '0;
         pre_o  <= '0;
         ctrl_o <= '0;
      end else if (wr_en_i) begin
         unique case (sel)
            SEL_CMP:  cmp_o  <= wr_data_i[CNT_W-1:0];
            SEL_PRE:  pre_o  <= wr_data_i[PRE_W-1:0];
            SEL_CTRL: ctrl_o <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
            default:  ;
         endcase
      end
   end

   always_comb begin
      rd_data_o = '0;
      unique case (sel)
         SEL_CMP:  rd_data_o[CNT_W-1:0]  = cmp_o;
         SEL_PRE:  rd_data_o[PRE_W-1:0]  = pre_o;
         SEL_CTRL: rd_data_o[CTRL_W-1:0] = ctrl_o;
         default:  rd_data_o = '0;
      endcase
   end

   // R10
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(ctrl_o));

endmodule

// File: rtl/pwm255_prescaler.sv
module pwm255_prescaler #(
   parameter int PRE_W   = 8,
   parameter bit DIV2_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [PRE_W-1:0] reload_i,
   output logic             tick_o
);

   logic             step;
   logic [PRE_W-1:0] down_q;

   generate
      if (DIV2_EN) begin : g_half
         logic phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     phase_q <= 1'b0;
            else if (run_i) phase_q <= ~phase_q;
         end
         assign step = run_i & phase_q;
      end else begin : g_full
         assign step = run_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         down_q <= '0;
      end else if (step) begin
         if (down_q == '0) down_q <= reload_i;
         else              down_q <= down_q - 1'b1;
      end
   end

   assign tick_o = step && (down_q == '0);

   // R8
   pre_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> $stable(down_q));

endmodule

// File: rtl/pwm255_counter.sv
module pwm255_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] act_o,
   output logic             wrap_o,
   output logic             raw_o
);

   // last counter state: all ones minus one, so all ones never matches
   localparam logic [CNT_W-1:0] TOP = {{(CNT_W-1){1'b1}}, 1'b0};

   assign wrap_o = tick_i && (cnt_o == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
         act_o <= '0;
      end else if (tick_i) begin
         if (wrap_o) begin
            cnt_o <= '0;
            act_o <= cmp_i;
         end else begin
            cnt_o <= cnt_o + 1'b1;
         end
      end
   end

   // set at match, clear at zero: high exactly while count >= active compare
   assign raw_o = (cnt_o >= act_o);

   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o <= TOP);

   // R1
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && cnt_o == TOP) |=> (cnt_o == '0));

   // R5
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick_i && cnt_o == TOP) |=> $stable(act_o));

endmodule

// File: rtl/pwm255_gen.sv
module pwm255_gen
   import pwm255_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int CNT_W   = 8,
   parameter int PRE_W   = 8,
   parameter bit DIV2_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle_i,
   input  logic              pdown_i,
   input  logic              wr_en_i,
   input  logic [1:0]        addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              io_out_i,
   output logic              pwm_pin_o,
   output logic              wrap_irq_o
);

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie in 2..DATA_W");
      end
      if (PRE_W < 1 || PRE_W > DATA_W) begin : g_bad_pre
         $error("PRE_W must lie in 1..DATA_W");
      end
   endgenerate

   logic             frozen;
   logic             tick;
   logic             wrap;
   logic             raw;
   logic [CNT_W-1:0] cmp_reg;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] act;
   logic [PRE_W-1:0] pre_reg;
   ctrl_t            ctrl;
   logic             irq_q;

   assign frozen = idle_i | pdown_i;

   pwm255_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
      .cmp_o(cmp_reg), .pre_o(pre_reg), .ctrl_o(ctrl)
   );

   pwm255_prescaler #(.PRE_W(PRE_W), .DIV2_EN(DIV2_EN)) pre_i (
      .clk(clk), .rst_n(rst_n), .run_i(~frozen), .reload_i(pre_reg),
      .tick_o(tick)
   );

   pwm255_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .cmp_i(cmp_reg),
      .cnt_o(cnt), .act_o(act), .wrap_o(wrap), .raw_o(raw)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= wrap & ctrl.irq_en;
   end
   assign wrap_irq_o = irq_q;

   always_comb begin
      if (!ctrl.out_en) pwm_pin_o = io_out_i;
      else if (frozen)  pwm_pin_o = 1'b1;
      else              pwm_pin_o = raw;
   end

   // R8
   cnt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_i || pdown_i) |=> $stable(cnt));

   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_irq_o |-> ($past(ctrl.irq_en) && cnt == '0));

   // R3
   set_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.out_en && !frozen && act == '0) |-> pwm_pin_o);

   // R4
   never_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.out_en && !frozen && act == '1) |-> !pwm_pin_o);

endmodule

// File: tb/pwm255_gen_tb_top.sv
module pwm255_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       idle_i = 1'b0;
   logic       pdown_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [1:0] addr_i = 2'd0;
   logic [7:0] wr_data_i = 8'd0;
   logic [7:0] rd_data_o;
   logic       io_out_i = 1'b0;
   logic       pwm_pin_o;
   logic       wrap_irq_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pwm255_gen dut_i (
      .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .pdown_i(pdown_i),
      .wr_en_i(wr_en_i), .addr_i(addr_i), .wr_data_i(wr_data_i),
      .rd_data_o(rd_data_o), .io_out_i(io_out_i), .pwm_pin_o(pwm_pin_o),
      .wrap_irq_o(wrap_irq_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input int exp, input string tag);
      @(negedge clk);
      addr_i = a;
      #1;
      chk(rd_data_o == exp[7:0], tag, rd_data_o, exp);
   endtask

   // wait at negedges until the wrap pulse is seen
   task automatic wait_irq(input int limit, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (wrap_irq_o) begin seen = 1'b1; break; end
      end
   endtask

   // one full period from a wrap pulse: count high pin samples, confirm next pulse
   task automatic period_chk(input int p, input int c, input string tag);
      bit seen;
      int n, hi, expv;
      n = 510 * (1 + p);
      wait_irq(n + 4, seen);          // first wrap loads the compare value
      wait_irq(n + 4, seen);
      chk(seen, {tag, " R1 wrap seen"}, seen, 1);
      hi = 0;
      for (int i = 0; i < n; i++) begin
         if (pwm_pin_o) hi++;
         @(negedge clk);
      end
      chk(wrap_irq_o == 1'b1, {tag, " R1 period"}, wrap_irq_o, 1);
      expv = (255 - c) * 2 * (1 + p);
      if (c == 0)        chk(hi == n, {tag, " R3 const high"}, hi, n);
      else if (c == 255) chk(hi == 0, {tag, " R4 const low"}, hi, 0);
      else               chk(hi == expv, {tag, " R2 duty"}, hi, expv);
   endtask

   initial begin
      bit seen;
      int n, hi, cnt_irq;
      int cmps[8] = '{0, 1, 2, 77, 128, 253, 254, 255};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R7 reset state
      rd_chk(2'd0, 0, "R7 cmp reset");
      rd_chk(2'd1, 0, "R7 pre reset");
      rd_chk(2'd2, 0, "R7 ctrl reset");
      io_out_i = 1'b1; #1;
      chk(pwm_pin_o == 1'b1, "R7 pin follows io 1", pwm_pin_o, 1);
      io_out_i = 1'b0; #1;
      chk(pwm_pin_o == 1'b0, "R7 pin follows io 0", pwm_pin_o, 0);

      // R10 readback
      wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'hFF);
      rd_chk(2'd0, 8'hA5, "R10 cmp readback");
      rd_chk(2'd1, 8'h3C, "R10 pre readback");
      rd_chk(2'd2, 3, "R10 ctrl readback");
      wr(2'd3, 8'h11);
      rd_chk(2'd3, 0, "R10 unused address");
      rd_chk(2'd0, 8'hA5, "R10 unused write ignored");

      // R1 R2 R3 R4 sweep
      for (int p = 0; p < 3; p++) begin
         foreach (cmps[k]) begin
            wr(2'd1, p[7:0]);
            wr(2'd0, cmps[k][7:0]);
            wr(2'd2, 8'h03);
            period_chk(p, cmps[k], $sformatf("p=%0d c=%0d", p, cmps[k]));
         end
      end

      // R5 mid-period compare change
      wr(2'd1, 8'd0); wr(2'd0, 8'd100); wr(2'd2, 8'h03);
      wait_irq(600, seen); wait_irq(600, seen);
      hi = 0;
      for (int i = 0; i < 510; i++) begin
         if (i == 10) begin wr_en_i = 1'b1; addr_i = 2'd0; wr_data_i = 8'd10; end
         if (i == 11) wr_en_i = 1'b0;
         if (pwm_pin_o) hi++;
         @(negedge clk);
      end
      chk(hi == 310, "R5 old compare kept this period", hi, 310);
      hi = 0;
      for (int i = 0; i < 510; i++) begin
         if (pwm_pin_o) hi++;
         @(negedge clk);
      end
      chk(hi == 490, "R5 new compare from next wrap", hi, 490);

      // R8 idle freeze: wrap delayed by idle length, pin high
      wait_irq(600, seen);
      hi = 0; n = 0;
      for (int i = 0; i < 510 + 37; i++) begin
         idle_i = (i >= 20 && i < 57);
         if (idle_i) begin n++; if (pwm_pin_o) hi++; end
         @(negedge clk);
      end
      idle_i = 1'b0;
      chk(hi == 37 && n == 37, "R8 pin high in idle", hi, 37);
      chk(wrap_irq_o == 1'b1, "R8 idle delays wrap", wrap_irq_o, 1);

      // R8 power-down freeze
      wait_irq(600, seen);
      for (int i = 0; i < 510 + 15; i++) begin
         pdown_i = (i >= 100 && i < 115);
         @(negedge clk);
         if (i < 509 + 15) chk_silent(wrap_irq_o);
      end
      pdown_i = 1'b0;
      chk(wrap_irq_o == 1'b1, "R8 power-down delays wrap", wrap_irq_o, 1);

      // R6 pin disabled: follows io, counter keeps running
      wr(2'd0, 8'd0); wr(2'd2, 8'h02);
      wait_irq(600, seen);
      hi = 0;
      for (int i = 0; i < 510; i++) begin
         io_out_i = i[3];
         #1;
         if (pwm_pin_o != io_out_i) hi++;
         @(negedge clk);
      end
      chk(hi == 0, "R6 pin follows io when disabled", hi, 0);
      chk(wrap_irq_o == 1'b1, "R6 counter runs while disabled", wrap_irq_o, 1);

      // R9 no pulse with interrupt disabled, single-clock pulse otherwise
      wr(2'd2, 8'h01);
      cnt_irq = 0;
      for (int i = 0; i < 1200; i++) begin
         @(negedge clk);
         if (wrap_irq_o) cnt_irq++;
      end
      chk(cnt_irq == 0, "R9 masked wrap gives no pulse", cnt_irq, 0);
      wr(2'd2, 8'h03);
      wait_irq(600, seen);
      @(negedge clk);
      chk(wrap_irq_o == 1'b0, "R9 pulse lasts one clock", wrap_irq_o, 0);

      done = 1'b1;
   end

   int silent_bad = 0;
   task automatic chk_silent(input logic v);
      if (v) silent_bad++;
   endtask

   initial begin
      int cycles = 0;
      while (!done && cycles < 190000) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) chk(1'b0, "watchdog expired", cycles, 190000);
      chk(silent_bad == 0, "R8 no early wrap in power-down", silent_bad, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule